// File: doc/BRIEF.md
# Carry-Save Shared Add/Subtract Unit

This block is a purely combinational arithmetic stage that sits behind a set of partial multipliers. It receives two operand pairs in carry-save form: a high-by-high sum and carry, and a low-by-low sum and carry. It also receives an accumulator value. A 3-bit opcode chooses what the unit does with them. It can pass the low pair through as a binary number, add the low pair to the accumulator, or subtract the low pair from the high pair. The unit never resolves either pair to binary before combining them.

All four selected vectors enter a four-input carry-save compressor. The compressor is two rows of full adders, followed by a single carry-propagate adder. Subtracting a carry-save number means inverting both of its halves, and that calls for two +1 corrections. One correction enters through the adder carry-in. The other goes into bit 0 of the high carry vector. Callers guarantee that this bit is zero, because carry vectors are always shifted one place left. For opcodes that use only the low pair, guarding AND gates hold the high-side inputs at zero. This keeps them quiet, which gives operand isolation at no extra cost.

Top module: `csa_addsub_unit`

## Requirements
- R1: For opcodes 1, 2, 3 and 7, result equals ll_sum + ll_carry.
- R2: For opcode 4, result equals (hh_sum + hh_carry) - (ll_sum + ll_carry).
- R3: For opcodes 5 and 6, result equals acc_in + ll_sum + ll_carry. The high-side compressor inputs carry acc_in and zero.
- R4: For opcode 0, result is zero whatever the operand inputs are.
- R5: For the low-only opcodes (1, 2, 3, 7), hh_sum, hh_carry and acc_in have no effect on result. For opcodes 5 and 6, hh_sum and hh_carry have no effect.
- R6: For opcode 4, both low vectors are inverted and the adder carry-in is 1. Bit 0 of the high carry compressor input is forced to 1. For every other opcode, the carry-in is 0.
- R7: Input contract: bit 0 of hh_carry and bit 0 of ll_carry is always zero.
- R8: All arithmetic is two's complement and wraps modulo 2^W (W = 32 by default).
- R9: The compressor's sum and carry vectors add up, modulo 2^W, to the sum of its four inputs.
- R10: For the low-only opcodes and opcode 0, both high-side compressor inputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation select |
| hh_sum | input | W | High-by-high partial product, sum vector |
| hh_carry | input | W | High-by-high partial product, carry vector (bit 0 zero) |
| ll_sum | input | W | Low-by-low partial product, sum vector |
| ll_carry | input | W | Low-by-low partial product, carry vector (bit 0 zero) |
| acc_in | input | W | Accumulator value |
| result | output | W | Binary result, modulo 2^W |

## Verification
Several properties are checked on every evaluation: the guarding of the high-side inputs, the accumulator routing, the placement of the two subtraction carries, the input contract on the carry LSBs, the zero output for opcode 0, and sum preservation through the compressor. The end-to-end value of each opcode, including wraparound at the extremes, is shown only by the bench scenarios. The same goes for the insensitivity of the result to unused operands. The bench compares each of these against an independent arithmetic model.

// File: rtl/csa_pkg.sv
package csa_pkg;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_FRAC_MUL  = 3'd1,
    OP_LOW_PROD  = 3'd2,
    OP_HIGH_PROD = 3'd3,
    OP_CPX_DIFF  = 3'd4,
    OP_ACC_ADD   = 3'd5,
    OP_ACC_RND   = 3'd6,
    OP_CS_COPY   = 3'd7
  } csa_op_e;

  typedef struct packed {
    logic lo_en;    // low pair enters the compressor
    logic hi_en;    // third-operand lane (high pair or accumulator) enabled
    logic sel_acc;  // third-operand mux picks accumulator
    logic sub;      // negate low pair
  } csa_ctrl_t;

  function automatic csa_ctrl_t csa_decode(csa_op_e op);
    csa_ctrl_t c;
    c.lo_en   = (op != OP_IDLE);
    c.hi_en   = (op == OP_CPX_DIFF) || (op == OP_ACC_ADD) || (op == OP_ACC_RND);
    c.sel_acc = (op == OP_ACC_ADD) || (op == OP_ACC_RND);
    c.sub     = (op == OP_CPX_DIFF);
    return c;
  endfunction

  function automatic logic fa_sum(logic a, logic b, logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/csa_opdecode.sv
module csa_opdecode
  import csa_pkg::*;
(
  input  logic [2:0] op_code,
  output csa_ctrl_t  ctrl
);
  csa_op_e op;
  always_comb begin
    op   = csa_op_e'(op_code);
    ctrl = csa_decode(op);
  end
endmodule

// File: rtl/csa_operand_prep.sv
module csa_operand_prep
  import csa_pkg::*;
#(
  parameter int W = 32
) (
  input  csa_ctrl_t      ctrl,
  input  logic [W-1:0]   hh_sum,
  input  logic [W-1:0]   hh_carry,
  input  logic [W-1:0]   ll_sum,
  input  logic [W-1:0]   ll_carry,
  input  logic [W-1:0]   acc_in,
  output logic [W-1:0]   opnd_a,
  output logic [W-1:0]   opnd_b,
  output logic [W-1:0]   opnd_c,
  output logic [W-1:0]   opnd_d,
  output logic           cin
);
  logic [W-1:0] hi_gate;
  logic [W-1:0] lo_gate;
  logic [W-1:0] neg_mask;
  logic [W-1:0] third_sel;
  logic [W-1:0] hh_carry_fix;
  logic         pair_lane;

  always_comb begin
    hi_gate   = {W{ctrl.hi_en}};
    lo_gate   = {W{ctrl.lo_en}};
    neg_mask  = {W{ctrl.sub}};
    pair_lane = ctrl.hi_en & ~ctrl.sel_acc;
    // third-operand mux: accumulator or high sum
    third_sel = ctrl.sel_acc ? acc_in : hh_sum;
    // second +1 of the negation rides in the always-zero LSB of the carry
    hh_carry_fix = {hh_carry[W-1:1], hh_carry[0] | ctrl.sub};
    opnd_a = hi_gate & third_sel;
    opnd_b = {W{pair_lane}} & hh_carry_fix;
    opnd_c = lo_gate & (ll_sum ^ neg_mask);
    opnd_d = lo_gate & (ll_carry ^ neg_mask);
    cin    = ctrl.sub;
  end
endmodule

// File: rtl/csa_compressor4.sv
module csa_compressor4
  import csa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] in_a,   // guarded, low activity: first row
  input  logic [W-1:0] in_b,   // guarded, low activity: first row
  input  logic [W-1:0] in_c,   // first row
  input  logic [W-1:0] in_d,   // most active: second row, near output
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] r1_s;
  logic [W-1:0] r1_k;
  logic [W-1:0] r1_k_sh;
  logic [W-1:0] r2_k;

  assign r1_k_sh = {r1_k[W-2:0], 1'b0};

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign r1_s[i]  = fa_sum  (in_a[i], in_b[i], in_c[i]);
    assign r1_k[i]  = fa_carry(in_a[i], in_b[i], in_c[i]);
    assign sum_o[i] = fa_sum  (r1_s[i], r1_k_sh[i], in_d[i]);
    assign r2_k[i]  = fa_carry(r1_s[i], r1_k_sh[i], in_d[i]);
  end

  assign carry_o = {r2_k[W-2:0], 1'b0};
endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s
);
  localparam int PADW = W - 1;
  assign s = x + y + {{PADW{1'b0}}, cin};
endmodule

// File: rtl/csa_addsub_unit.sv
module csa_addsub_unit
  import csa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op_code,
  input  logic [W-1:0] hh_sum,
  input  logic [W-1:0] hh_carry,
  input  logic [W-1:0] ll_sum,
  input  logic [W-1:0] ll_carry,
  input  logic [W-1:0] acc_in,
  output logic [W-1:0] result
);
  csa_ctrl_t    ctl;
  logic [W-1:0] opnd_a, opnd_b, opnd_c, opnd_d;
  logic         prep_cin;
  logic [W-1:0] cmp_sum, cmp_carry;

  csa_opdecode u_dec (
    .op_code (op_code),
    .ctrl    (ctl)
  );

  csa_operand_prep #(.W(W)) u_prep (
    .ctrl     (ctl),
    .hh_sum   (hh_sum),
    .hh_carry (hh_carry),
    .ll_sum   (ll_sum),
    .ll_carry (ll_carry),
    .acc_in   (acc_in),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .opnd_c   (opnd_c),
    .opnd_d   (opnd_d),
    .cin      (prep_cin)
  );

  csa_compressor4 #(.W(W)) u_cmp (
    .in_a    (opnd_a),
    .in_b    (opnd_b),
    .in_c    (opnd_c),
    .in_d    (opnd_d),
    .sum_o   (cmp_sum),
    .carry_o (cmp_carry)
  );

  csa_cpa #(.W(W)) u_cpa (
    .x   (cmp_sum),
    .y   (cmp_carry),
    .cin (prep_cin),
    .s   (result)
  );
endmodule

// File: rtl/csa_addsub_chk.sv
module csa_addsub_chk
  import csa_pkg::*;
#(
  parameter int W = 32
) (
  input logic [2:0]   op_code,
  input logic [W-1:0] hh_carry,
  input logic [W-1:0] ll_carry,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] opnd_c,
  input logic [W-1:0] opnd_d,
  input logic         prep_cin,
  input logic [W-1:0] cmp_sum,
  input logic [W-1:0] cmp_carry,
  input logic [W-1:0] result
);
  csa_op_e op;
  logic    lo_only;
  logic    acc_op;
  logic    is_diff;

  always_comb begin
    op      = csa_op_e'(op_code);
    lo_only = (op == OP_FRAC_MUL) || (op == OP_LOW_PROD) ||
              (op == OP_HIGH_PROD) || (op == OP_CS_COPY) || (op == OP_IDLE);
    acc_op  = (op == OP_ACC_ADD) || (op == OP_ACC_RND);
    is_diff = (op == OP_CPX_DIFF);

    p_guard_hi_r10: assert (!lo_only || (opnd_a == '0 && opnd_b == '0))
      else $error("high-side inputs not guarded");
    p_acc_route_r3: assert (!acc_op || (opnd_a == acc_in && opnd_b == '0))
      else $error("accumulator routing wrong");
    p_sub_cin_r6: assert (prep_cin == is_diff)
      else $error("carry-in mismatch");
    p_sub_lsb_r6: assert (!is_diff || opnd_b[0])
      else $error("second negation carry missing");
    p_input_lsb_r7: assert (hh_carry[0] == 1'b0 && ll_carry[0] == 1'b0)
      else $error("carry vector LSB not zero");
    p_compress_r9: assert (cmp_sum + cmp_carry == opnd_a + opnd_b + opnd_c + opnd_d)
      else $error("compressor loses value");
    p_idle_zero_r4: assert (op != OP_IDLE || result == '0)
      else $error("idle opcode result not zero");
  end
endmodule

bind csa_addsub_unit csa_addsub_chk #(.W(W)) u_chk (
  .op_code   (op_code),
  .hh_carry  (hh_carry),
  .ll_carry  (ll_carry),
  .acc_in    (acc_in),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .opnd_c    (opnd_c),
  .opnd_d    (opnd_d),
  .prep_cin  (prep_cin),
  .cmp_sum   (cmp_sum),
  .cmp_carry (cmp_carry),
  .result    (result)
);

// File: tb/tb_csa_addsub_unit.sv
`timescale 1ns/1ps
module tb_csa_addsub_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op_code = '0;
  logic [W-1:0] hh_sum = '0, hh_carry = '0, ll_sum = '0, ll_carry = '0, acc_in = '0;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz

  csa_addsub_unit #(.W(W)) dut (
    .op_code  (op_code),
    .hh_sum   (hh_sum),
    .hh_carry (hh_carry),
    .ll_sum   (ll_sum),
    .ll_carry (ll_carry),
    .acc_in   (acc_in),
    .result   (result)
  );

  // behavioural model in wide integers, reduced to W bits
  function automatic logic [W-1:0] model(int op, longint hs, longint hc,
                                         longint ls, longint lc, longint acc);
    longint v;
    case (op)
      1, 2, 3, 7: v = ls + lc;
      4:          v = (hs + hc) - (ls + lc);
      5, 6:       v = acc + ls + lc;
      default:    v = 0;
    endcase
    return v[W-1:0];
  endfunction

  task automatic run(input int op, input logic [W-1:0] hs, input logic [W-1:0] hc,
                     input logic [W-1:0] ls, input logic [W-1:0] lc,
                     input logic [W-1:0] acc, input string tag);
    logic [W-1:0] e;
    @(posedge clk);
    op_code  = 3'(op);
    hh_sum   = hs;
    hh_carry = hc;
    ll_sum   = ls;
    ll_carry = lc;
    acc_in   = acc;
    exp_q.push_back(model(op, longint'(hs), longint'(hc), longint'(ls),
                          longint'(lc), longint'(acc)));
    @(negedge clk);
    e = exp_q.pop_front();
    checks++;
    if (result !== e) begin
      errors++;
      $display("FAIL %s op=%0d actual=%h expected=%h", tag, op, result, e);
    end
  endtask

  function automatic logic [W-1:0] rcar();
    return $urandom() & 32'hFFFF_FFFE;  // R7: carry LSB is zero
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // reset state: all inputs zero, R4
    if (result !== '0) begin
      errors++;
      $display("FAIL R4 reset actual=%h expected=%h", result, 32'h0);
    end

    // R1 low-only opcodes
    run(1, 32'h0, 32'h0, 32'h0000_1234, 32'h0000_0010, 32'h0, "R1");
    run(2, 32'h0, 32'h0, 32'h7FFF_FFFF, 32'h0000_0002, 32'h0, "R1");
    run(3, 32'h0, 32'h0, 32'hDEAD_BEEF, 32'h1111_1110, 32'h0, "R1");
    run(7, 32'h0, 32'h0, 32'h8000_0000, 32'h8000_0000, 32'h0, "R1_R8");
    // R5 unused inputs have no effect
    run(2, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0100, 32'h0000_0020, 32'hFFFF_FFFF, "R5");
    run(2, 32'h1234_5678, 32'h0F0F_0F0E, 32'h0000_0100, 32'h0000_0020, 32'h5555_5555, "R5");
    run(5, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h0000_0003, 32'h0000_0004, 32'h0000_0010, "R5");
    // R2 subtraction corners
    run(4, 32'h0000_0050, 32'h0000_0050, 32'h0000_0050, 32'h0000_0050, 32'h0, "R2_equal");
    run(4, 32'h0, 32'h0, 32'h0000_0001, 32'h0, 32'h0, "R2_R6_neg1");
    run(4, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0, "R2_R8");
    run(4, 32'h8000_0000, 32'h0, 32'h0000_0001, 32'h0, 32'h0, "R2_R8_minwrap");
    // R3 accumulate
    run(5, 32'h0, 32'h0, 32'h0000_0001, 32'h0, 32'hFFFF_FFFF, "R3_R8");
    run(6, 32'h0, 32'h0, 32'h1000_0000, 32'h2000_0000, 32'h0300_0000, "R3");
    // R4 idle with busy inputs
    run(0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R4");

    // random sweep over all opcodes; R9/R10/R6 also watched by the checker
    for (int n = 0; n < 800; n++) begin
      run(n % 8, $urandom(), rcar(), $urandom(), rcar(), $urandom(), "R1_R2_R3_R4_sweep");
    end

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule